// File: doc/BRIEF.md
# Packed Floating-Point Round-to-Integral Unit

This block takes a packed vector of floating-point lanes and rounds every lane to the nearest integral value. The result stays in the lane's own floating-point format and is not converted to an integer. Ties go to the even neighbour. Lanes can be half precision (four per 64-bit half) or single precision (two per 64-bit half). A width select picks either the low 64-bit half alone or both halves of a 128-bit operand.

Besides the result vector, the unit reports three flags for each operation. The inexact flag is the OR over the active lanes of "the value changed". The invalid flag shows that a signalling NaN was quietened. The undefined flag rejects an encoding the unit does not accept. Every output is registered, so a result appears one clock after its operand.

Top module: `fpri_top`

## Requirements
- R1: With `lane_sel` = 2'b10, each 32-bit lane (bit 31 sign, bits 30:23 exponent with bias 127, bits 22:0 fraction) is rounded to the nearest integral value, with ties to even. For example, 2.5 gives 2.0, 3.5 gives 4.0 and -2.5 gives -2.0.
- R2: With `lane_sel` = 2'b01 and `fp16_en` = 1, each 16-bit lane (bit 15 sign, bits 14:10 exponent with bias 15, bits 9:0 fraction) is rounded the same way, four lanes per 64 bits.
- R3: `flag_inexact` is 1 exactly when at least one active lane that is neither NaN nor infinity produces a result that differs from its input.
- R4: A zero or an infinity passes through with its sign unchanged and raises no flag.
- R5: A signalling NaN (exponent all ones, nonzero fraction, top fraction bit 0) comes out with its top fraction bit set and raises `flag_invalid`. A quiet NaN passes through unchanged and raises no flag.
- R6: A nonzero lane below 0.5 in magnitude, denormals included, becomes a zero of the same sign. A lane of exactly ±0.5 becomes a signed zero. A lane in (0.5, 1) becomes ±1.0. All of these raise inexact.
- R7: A value that rounds up across a power of two gets its exponent incremented and its fraction cleared. For example, 8388607.5 in single precision gives 2^23, and 1023.5 in half precision gives 1024.
- R8: A lane whose unbiased exponent is at least the fraction width, up to and including the largest finite value, is already integral and passes through unchanged.
- R9: `lane_sel` codes 2'b00 and 2'b11 are undefined. Code 2'b01 is undefined while `fp16_en` is 0.
- R10: With `wide` = 1, an odd source or destination index (`src_odd` or `dst_odd` = 1) is undefined. With `wide` = 0, those two inputs have no effect.
- R11: With `wide` = 0, only bits 63:0 are processed. Bits 127:64 of the result are zero, and upper lanes influence no flag.
- R12: For an undefined operation, `flag_undef` is 1, and the result and the other two flags are zero.
- R13: All outputs are registered and are due one clock after their operand. Synchronous reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vec | input | 128 | Packed source lanes |
| lane_sel | input | 2 | Lane-size code: 01 = 16-bit, 10 = 32-bit, others undefined |
| wide | input | 1 | 1 = both 64-bit halves, 0 = low half only |
| fp16_en | input | 1 | Half-precision support enabled |
| src_odd | input | 1 | Source register index is odd |
| dst_odd | input | 1 | Destination register index is odd |
| res_vec | output | 128 | Rounded lanes |
| flag_inexact | output | 1 | Some active lane changed value |
| flag_invalid | output | 1 | Some active lane held a signalling NaN |
| flag_undef | output | 1 | Operation encoding rejected |

## Verification
All four outputs, the result vector and the three flags, sit behind one register stage. The value applied at one falling clock edge is therefore due at the next falling edge. The bench drives each operand on a falling edge and pushes the expected result from its behavioural ties-to-even model into a queue. At the following falling edge, one rising edge later, it pops that entry and compares it against the outputs, so every sample lands exactly one register past its stimulus. The reset state is sampled while reset is held, before the first operand is queued.

// File: rtl/fpri_pkg.sv
package fpri_pkg;

    typedef enum logic [1:0] {
        LS_RSV_LO = 2'b00,
        LS_H16    = 2'b01,
        LS_S32    = 2'b10,
        LS_RSV_HI = 2'b11
    } lane_sel_e;

    typedef struct packed {
        logic inexact;
        logic invalid;
    } lane_flags_t;

    typedef struct packed {
        logic undef;
        logic use_h16;
        logic upper_on;
    } op_ctl_t;

    localparam int H_EXP_W  = 5;
    localparam int H_FRAC_W = 10;
    localparam int S_EXP_W  = 8;
    localparam int S_FRAC_W = 23;

endpackage

// File: rtl/fpri_decode.sv
module fpri_decode
    import fpri_pkg::*;
(
    input  logic [1:0] lane_sel,
    input  logic       wide,
    input  logic       fp16_en,
    input  logic       src_odd,
    input  logic       dst_odd,
    output op_ctl_t    ctl
);
    logic size_ok;
    logic pair_bad;

    always_comb begin
        size_ok      = (lane_sel == LS_S32) || ((lane_sel == LS_H16) && fp16_en);
        pair_bad     = wide && (src_odd || dst_odd);
        ctl.undef    = !size_ok || pair_bad;
        ctl.use_h16  = (lane_sel == LS_H16);
        ctl.upper_on = wide;
    end
endmodule

// File: rtl/fpri_lane.sv
module fpri_lane
    import fpri_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] lane_in,
    output logic [EXP_W+FRAC_W:0] lane_out,
    output lane_flags_t           flags
);
    localparam int MAG_W = EXP_W + FRAC_W;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] E_ONE  = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] E_HALF = EXP_W'(BIAS - 1);
    localparam logic [EXP_W-1:0] E_INT  = EXP_W'(BIAS + FRAC_W);

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic [MAG_W-1:0]  mag, step, half_step, low_mask, rounded;
    logic [EXP_W:0]    kshift;
    logic              guard, sticky, lsb;

    always_comb begin
        sgn       = lane_in[MAG_W];
        ex        = lane_in[MAG_W-1:FRAC_W];
        fr        = lane_in[FRAC_W-1:0];
        mag       = lane_in[MAG_W-1:0];
        // number of fraction bits below the integer point (valid for E_ONE..E_INT-1)
        kshift    = {1'b0, E_INT} - {1'b0, ex};
        step      = MAG_W'(1) << kshift;
        half_step = step >> 1;
        low_mask  = step - MAG_W'(1);
        guard     = |(mag & half_step);
        sticky    = |(mag & (half_step - MAG_W'(1)));
        lsb       = |(mag & step);
        // carry out of the fraction lands in the exponent, renormalising for free
        rounded   = (mag & ~low_mask) + ((guard && (sticky || lsb)) ? step : '0);

        lane_out  = lane_in;
        flags     = '0;
        if (ex == '1) begin
            if ((fr != '0) && !fr[FRAC_W-1]) begin
                lane_out[FRAC_W-1] = 1'b1;
                flags.invalid      = 1'b1;
            end
        end else if (ex >= E_INT) begin
            lane_out = lane_in;
        end else if (ex < E_HALF) begin
            if (mag != '0) begin
                lane_out      = {sgn, {MAG_W{1'b0}}};
                flags.inexact = 1'b1;
            end
        end else if (ex == E_HALF) begin
            flags.inexact = 1'b1;
            if (fr == '0) lane_out = {sgn, {MAG_W{1'b0}}};
            else          lane_out = {sgn, E_ONE, {FRAC_W{1'b0}}};
        end else begin
            lane_out      = {sgn, rounded};
            flags.inexact = |(mag & low_mask);
        end
    end
endmodule

// File: rtl/fpri_top.sv
module fpri_top
    import fpri_pkg::*;
#(
    parameter int HALF_W     = 64,
    parameter int MAX_HALVES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [HALF_W*MAX_HALVES-1:0] op_vec,
    input  logic [1:0]                   lane_sel,
    input  logic                         wide,
    input  logic                         fp16_en,
    input  logic                         src_odd,
    input  logic                         dst_odd,
    output logic [HALF_W*MAX_HALVES-1:0] res_vec,
    output logic                         flag_inexact,
    output logic                         flag_invalid,
    output logic                         flag_undef
);
    localparam int VEC_W      = HALF_W * MAX_HALVES;
    localparam int H_W        = 1 + H_EXP_W + H_FRAC_W;
    localparam int S_W        = 1 + S_EXP_W + S_FRAC_W;
    localparam int H_LANES    = VEC_W / H_W;
    localparam int S_LANES    = VEC_W / S_W;
    localparam int H_PER_HALF = HALF_W / H_W;
    localparam int S_PER_HALF = HALF_W / S_W;

    op_ctl_t ctl;

    fpri_decode u_dec (
        .lane_sel (lane_sel),
        .wide     (wide),
        .fp16_en  (fp16_en),
        .src_odd  (src_odd),
        .dst_odd  (dst_odd),
        .ctl      (ctl)
    );

    logic [VEC_W-1:0]   h_res, s_res, act_bits, nxt_res;
    logic [H_LANES-1:0] h_inx, h_inv;
    logic [S_LANES-1:0] s_inx, s_inv;
    logic               nxt_inx, nxt_inv;

    for (genvar gi = 0; gi < H_LANES; gi++) begin : g_h
        lane_flags_t fl;
        logic        act;
        fpri_lane #(.EXP_W(H_EXP_W), .FRAC_W(H_FRAC_W)) u_lane (
            .lane_in  (op_vec[gi*H_W +: H_W]),
            .lane_out (h_res[gi*H_W +: H_W]),
            .flags    (fl)
        );
        assign act       = (gi < H_PER_HALF) || ctl.upper_on;
        assign h_inx[gi] = fl.inexact && act;
        assign h_inv[gi] = fl.invalid && act;
    end

    for (genvar gj = 0; gj < S_LANES; gj++) begin : g_s
        lane_flags_t fl;
        logic        act;
        fpri_lane #(.EXP_W(S_EXP_W), .FRAC_W(S_FRAC_W)) u_lane (
            .lane_in  (op_vec[gj*S_W +: S_W]),
            .lane_out (s_res[gj*S_W +: S_W]),
            .flags    (fl)
        );
        assign act       = (gj < S_PER_HALF) || ctl.upper_on;
        assign s_inx[gj] = fl.inexact && act;
        assign s_inv[gj] = fl.invalid && act;
    end

    always_comb begin
        act_bits = ctl.upper_on ? {VEC_W{1'b1}}
                                : {{(VEC_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
        nxt_res  = (ctl.use_h16 ? h_res : s_res) & act_bits;
        nxt_inx  = ctl.use_h16 ? |h_inx : |s_inx;
        nxt_inv  = ctl.use_h16 ? |h_inv : |s_inv;
        if (ctl.undef) begin
            nxt_res = '0;
            nxt_inx = 1'b0;
            nxt_inv = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vec      <= '0;
            flag_inexact <= 1'b0;
            flag_invalid <= 1'b0;
            flag_undef   <= 1'b0;
        end else begin
            res_vec      <= nxt_res;
            flag_inexact <= nxt_inx;
            flag_invalid <= nxt_inv;
            flag_undef   <= ctl.undef;
        end
    end
endmodule

// File: rtl/fpri_checker.sv
module fpri_checker #(
    parameter int HALF_W = 64,
    parameter int VEC_W  = 128
) (
    input logic             clk,
    input logic             rst,
    input logic [VEC_W-1:0] op_vec,
    input logic [1:0]       lane_sel,
    input logic             wide,
    input logic             fp16_en,
    input logic             src_odd,
    input logic             dst_odd,
    input logic [VEC_W-1:0] res_vec,
    input logic             flag_inexact,
    input logic             flag_invalid,
    input logic             flag_undef
);
    a_r9_reserved_code: assert property (@(posedge clk) disable iff (rst)
        (lane_sel == 2'b00 || lane_sel == 2'b11) |=> flag_undef);

    a_r9_half_disabled: assert property (@(posedge clk) disable iff (rst)
        (lane_sel == 2'b01 && !fp16_en) |=> flag_undef);

    a_r10_odd_pair: assert property (@(posedge clk) disable iff (rst)
        (wide && (src_odd || dst_odd)) |=> flag_undef);

    a_r12_quiet_undef: assert property (@(posedge clk) disable iff (rst)
        flag_undef |-> (res_vec == '0 && !flag_inexact && !flag_invalid));

    a_r11_upper_clear: assert property (@(posedge clk) disable iff (rst)
        !wide |=> (res_vec[VEC_W-1:HALF_W] == '0));

    a_r4_zero_exact: assert property (@(posedge clk) disable iff (rst)
        (op_vec == '0 && lane_sel == 2'b10) |=> (res_vec == '0 && !flag_inexact && !flag_invalid));
endmodule

bind fpri_top fpri_checker #(.HALF_W(HALF_W), .VEC_W(VEC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_vec       (op_vec),
    .lane_sel     (lane_sel),
    .wide         (wide),
    .fp16_en      (fp16_en),
    .src_odd      (src_odd),
    .dst_odd      (dst_odd),
    .res_vec      (res_vec),
    .flag_inexact (flag_inexact),
    .flag_invalid (flag_invalid),
    .flag_undef   (flag_undef)
);

// File: tb/tb_fpri_top.sv
module tb_fpri_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] op_vec = '0;
    logic [1:0]   lane_sel = 2'b10;
    logic         wide = 1'b0, fp16_en = 1'b1, src_odd = 1'b0, dst_odd = 1'b0;
    logic [127:0] res_vec;
    logic         flag_inexact, flag_invalid, flag_undef;

    int n_vec = 0;
    int n_bad = 0;
    longint unsigned rng = 64'h9E3779B97F4A7C15;

    always #2 clk = ~clk;

    fpri_top dut (
        .clk(clk), .rst(rst), .op_vec(op_vec), .lane_sel(lane_sel), .wide(wide),
        .fp16_en(fp16_en), .src_odd(src_odd), .dst_odd(dst_odd), .res_vec(res_vec),
        .flag_inexact(flag_inexact), .flag_invalid(flag_invalid), .flag_undef(flag_undef)
    );

    typedef struct {
        logic [127:0] res;
        logic         inx, inv, und;
        string        tag;
    } expect_t;
    expect_t pend[$];

    function automatic longint unsigned next_rand();
        rng ^= rng << 13;
        rng ^= rng >> 7;
        rng ^= rng << 17;
        return rng;
    endfunction

    // behavioural ties-to-even model on unsigned integers
    function automatic longint unsigned model_lane(longint unsigned x, int ew, int fw,
                                                   output bit inx, output bit inv);
        longint unsigned fmask, f, e, sgn, m, q, rem, half, sbit;
        int bias, u, k, p;
        fmask = (64'd1 << fw) - 1;
        f     = x & fmask;
        e     = (x >> fw) & ((64'd1 << ew) - 1);
        sgn   = (x >> (ew + fw)) & 1;
        sbit  = sgn << (ew + fw);
        bias  = (1 << (ew - 1)) - 1;
        inx   = 0;
        inv   = 0;
        if (e == (64'd1 << ew) - 1) begin
            if (f != 0 && ((f >> (fw - 1)) & 1) == 0) begin
                inv = 1;
                return x | (64'd1 << (fw - 1));
            end
            return x;
        end
        if (e == 0 && f == 0) return x;
        u = int'(e) - bias;
        if (u >= fw) return x;
        if (u < -1) begin
            inx = 1;
            return sbit;
        end
        m    = (64'd1 << fw) | f;
        k    = fw - u;
        q    = m >> k;
        rem  = m - (q << k);
        half = 64'd1 << (k - 1);
        if (rem > half || (rem == half && q[0])) q = q + 1;
        if (rem != 0) inx = 1;
        if (q == 0) return sbit;
        p = 0;
        while ((q >> (p + 1)) != 0) p++;
        return sbit | (longint'(bias + p) << fw) | ((q << (fw - p)) & fmask);
    endfunction

    task automatic check_pending();
        expect_t ex;
        if (pend.size() == 0) return;
        ex = pend.pop_front();
        n_vec++;
        if (res_vec !== ex.res || flag_inexact !== ex.inx || flag_invalid !== ex.inv
            || flag_undef !== ex.und) begin
            n_bad++;
            $display("FAIL %s: got res=%h ix/iv/ud=%b%b%b expected res=%h ix/iv/ud=%b%b%b",
                     ex.tag, res_vec, flag_inexact, flag_invalid, flag_undef,
                     ex.res, ex.inx, ex.inv, ex.und);
        end
    endtask

    task automatic apply(input logic [127:0] v, input logic [1:0] sel, input logic w,
                         input logic h_en, input logic so, input logic dodd, input string tag);
        expect_t ex;
        int      lw, ew, fw, nl;
        bit      li, lv;
        longint unsigned r;
        @(negedge clk);
        check_pending();
        op_vec = v; lane_sel = sel; wide = w; fp16_en = h_en; src_odd = so; dst_odd = dodd;
        ex.res = '0; ex.inx = 0; ex.inv = 0; ex.tag = tag;
        ex.und = !(sel == 2'b10 || (sel == 2'b01 && h_en)) || (w && (so || dodd));
        if (!ex.und) begin
            lw = (sel == 2'b01) ? 16 : 32;
            ew = (sel == 2'b01) ? 5 : 8;
            fw = (sel == 2'b01) ? 10 : 23;
            nl = (w ? 128 : 64) / lw;
            for (int i = 0; i < nl; i++) begin
                r = model_lane(longint'(v[i*lw +: 32]) & ((64'd1 << lw) - 1), ew, fw, li, lv);
                if (lw == 16) ex.res[i*16 +: 16] = r[15:0];
                else          ex.res[i*32 +: 32] = r[31:0];
                ex.inx |= li;
                ex.inv |= lv;
            end
        end
        pend.push_back(ex);
    endtask

    function automatic logic [127:0] s4(logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [31:0] d);
        return {d, c, b, a};
    endfunction

    function automatic logic [63:0] h4(logic [15:0] a, logic [15:0] b, logic [15:0] c, logic [15:0] d);
        return {d, c, b, a};
    endfunction

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] v;
        repeat (3) @(negedge clk);
        n_vec++;
        if (res_vec !== '0 || flag_inexact || flag_invalid || flag_undef) begin
            n_bad++;
            $display("FAIL R13 reset: got %h %b%b%b expected zero", res_vec,
                     flag_inexact, flag_invalid, flag_undef);
        end
        rst = 1'b0;

        // single precision ties, signs
        apply(s4(32'h40200000, 32'h40600000, 32'hC0200000, 32'h3FC00000), 2'b10, 1, 1, 0, 0, "R1 ties");
        apply(s4(32'h40000000, 32'h41200000, 32'h40000000, 32'h40000000), 2'b10, 1, 1, 0, 0, "R3 exact no inexact");
        apply(s4(32'h00000000, 32'h80000000, 32'h7F800000, 32'hFF800000), 2'b10, 1, 1, 0, 0, "R4 zero inf");
        apply(s4(32'h7F800001, 32'h7FC00000, 32'h40000000, 32'hFFA00000), 2'b10, 1, 1, 0, 0, "R5 nan");
        apply(s4(32'h7FC00000, 32'h7FC12345, 32'h3F800000, 32'h00000000), 2'b10, 1, 1, 0, 0, "R5 quiet only");
        apply(s4(32'h00000001, 32'hBF000000, 32'h3F400000, 32'h3E99999A), 2'b10, 1, 1, 0, 0, "R6 small");
        apply(s4(32'h3F000000, 32'h807FFFFF, 32'hBF7FFFFF, 32'h3F000001), 2'b10, 1, 1, 0, 0, "R6 half");
        apply(s4(32'h4AFFFFFF, 32'h3FFFFFFF, 32'hCAFFFFFF, 32'h4B000000), 2'b10, 1, 1, 0, 0, "R7 binade");
        apply(s4(32'h7F7FFFFF, 32'hFF7FFFFF, 32'h4B000001, 32'h4B7FFFFF), 2'b10, 1, 1, 0, 0, "R8 large");

        // half precision
        apply({h4(16'h4100, 16'h4300, 16'hC100, 16'h3E00), h4(16'h4500, 16'h4700, 16'h3C00, 16'h4000)},
              2'b01, 1, 1, 0, 0, "R2 ties");
        apply({h4(16'h0001, 16'hB800, 16'h3A00, 16'h3800), h4(16'h63FF, 16'h7BFF, 16'h7C01, 16'h7E00)},
              2'b01, 1, 1, 0, 0, "R2 R6 R7 R5 R8");
        apply({h4(16'h0000, 16'h8000, 16'h7C00, 16'hFC00), h4(16'h6400, 16'h4000, 16'h3C00, 16'h0000)},
              2'b01, 1, 1, 0, 0, "R4 half");

        // width and undefined cases
        apply(s4(32'h40200000, 32'h40000000, 32'h7F800001, 32'h3F400000), 2'b10, 0, 1, 0, 0, "R11 narrow");
        apply(s4(32'h40000000, 32'h40000000, 32'h7F800001, 32'h3F400000), 2'b10, 0, 1, 1, 1, "R10 R11 narrow odd");
        apply(s4(32'h40200000, 32'h40000000, 32'h7F800001, 32'h3F400000), 2'b10, 1, 1, 1, 0, "R10 odd src");
        apply(s4(32'h40200000, 32'h40000000, 32'h7F800001, 32'h3F400000), 2'b10, 1, 1, 0, 1, "R10 odd dst");
        apply(s4(32'h40200000, 32'h7F800001, 32'h0, 32'h0), 2'b00, 1, 1, 0, 0, "R9 R12 code00");
        apply(s4(32'h40200000, 32'h7F800001, 32'h0, 32'h0), 2'b11, 0, 1, 0, 0, "R9 R12 code11");
        apply(s4(32'h41004100, 32'h7C017C01, 32'h0, 32'h0), 2'b01, 0, 0, 0, 0, "R9 R12 half off");
        apply(s4(32'h41004100, 32'h7C017C01, 32'h0, 32'h0), 2'b01, 0, 1, 0, 0, "R2 R11 half narrow");

        // pseudo-random sweep, shaped exponents in the rounding range
        for (int n = 0; n < 600; n++) begin
            logic [1:0] sel;
            logic       w, he, so, dd;
            string      tg;
            v = {next_rand(), next_rand()};
            sel = (n % 7 == 6) ? 2'(next_rand()) : ((n % 2 == 0) ? 2'b10 : 2'b01);
            w   = next_rand() % 2 == 0;
            he  = next_rand() % 8 != 0;
            so  = next_rand() % 10 == 0;
            dd  = next_rand() % 10 == 0;
            if (n % 3 != 0) begin
                if (sel == 2'b01) begin
                    for (int i = 0; i < 8; i++) v[i*16+10 +: 5] = 5'(14 + next_rand() % 12);
                end else begin
                    for (int i = 0; i < 4; i++) v[i*32+23 +: 8] = 8'(126 + next_rand() % 25);
                end
            end
            tg = (sel == 2'b01) ? "R2 R3 sweep" : "R1 R3 sweep";
            apply(v, sel, w, he, so, dd, tg);
        end

        @(negedge clk);
        check_pending();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule